// File: doc/BRIEF.md
# Sticky ADC Overrange Peak Detector

This block sits beside one ADC channel and watches its signed, two's-complement sample stream. Each valid sample is reduced to its magnitude and placed into one of four bands around full scale: well below full scale, just below it, just above it, and well above it. The block keeps the highest band reached so far as a 2-bit code that a status register can present to software, so a single read tells how close the channel came to clipping since the code was last cleared.

The code is sticky and only ever rises. It falls back to the lowest band on one of two events: a write to the status register that holds it, or the channel being switched off through its enable input. The three band edges are parameters in sample units, so the same block serves converters of different widths and headroom settings. The ADC itself and any conversion to decibels stay outside.

Top module: `ovr_peak_top`

## Requirements
- R1: With magnitude m, the band code is 2'b00 when m < TH_NEAR, 2'b01 when TH_NEAR <= m < TH_OVER, 2'b10 when TH_OVER <= m < TH_HIGH and 2'b11 when m >= TH_HIGH (defaults 14600, 16384, 18384 for a 16-bit sample).
- R2: The magnitude is the absolute value of the two's-complement sample; the most negative sample gives the largest positive magnitude (2^(W-1)-1).
- R3: One clock after a valid sample on an enabled channel, peak_code equals the larger of its previous value and that sample's band code.
- R4: Without a clear, peak_code never decreases, and a cycle with smp_valid low leaves it unchanged whatever smp_data holds.
- R5: A cycle with stat_wr high and no valid sample sets peak_code to 2'b00 on the next clock.
- R6: While chan_en is low, peak_code is 2'b00 one clock later and samples, even valid ones, are ignored.
- R7: When stat_wr and a valid sample coincide on an enabled channel, peak_code after the clock equals that sample's band code alone.
- R8: After reset (rst_n low), peak_code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | smp_data carries a new sample this cycle |
| smp_data | input | W | Signed two's-complement ADC sample |
| stat_wr | input | 1 | Write strobe to the status register holding the code |
| chan_en | input | 1 | Channel power enable; low means powered down |
| peak_code | output | 2 | Highest band seen since the last clear |

## Verification
The hardest situation to reach is a clear landing in the very cycle a sample arrives, together with a sample exactly on a band edge or at the most negative value, since ordinary traffic rarely lines these up. The stimulus drives each threshold value and the value one below it directly, pushes the most negative sample after a clear, and issues a status write in the same cycle as a high-band sample and as a low-band sample so that the result must come from the new sample and not from the stored peak. Disabled-channel cycles carry valid full-scale samples to show they are dropped.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

  typedef enum logic [1:0] {
    RNG_QUIET = 2'b00,
    RNG_NEAR  = 2'b01,
    RNG_OVER  = 2'b10,
    RNG_HIGH  = 2'b11
  } rng_code_t;

  function automatic rng_code_t rng_max(input rng_code_t a, input rng_code_t b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ovr_mag.sv
module ovr_mag #(
  parameter int W = 16,
  localparam int MW = W - 1
) (
  input  logic [W-1:0]  smp,
  output logic [MW-1:0] mag,
  output logic          sat_hit
);

  function automatic logic [MW-1:0] abs_sat(input logic [W-1:0] s);
    logic [W-1:0] neg;
    neg = ~s + 1'b1;
    if (!s[W-1])
      return s[MW-1:0];
    else if (neg[W-1])
      return '1;
    else
      return neg[MW-1:0];
  endfunction

  assign mag     = abs_sat(smp);
  assign sat_hit = smp[W-1] && (smp[MW-1:0] == '0);

  always_comb begin
    if (sat_hit)
      a_r2_min_saturates: assert (&mag);
  end

endmodule

// File: rtl/ovr_classify.sv
module ovr_classify
  import ovr_pkg::*;
#(
  parameter int MW      = 15,
  parameter int TH_NEAR = 14600,
  parameter int TH_OVER = 16384,
  parameter int TH_HIGH = 18384
) (
  input  logic [MW-1:0] mag,
  output rng_code_t     code
);

  localparam logic [MW:0] T_NEAR = (MW+1)'(TH_NEAR);
  localparam logic [MW:0] T_OVER = (MW+1)'(TH_OVER);
  localparam logic [MW:0] T_HIGH = (MW+1)'(TH_HIGH);

  logic [MW:0] m_ext;
  logic        ge_near, ge_over, ge_high;

  assign m_ext   = {1'b0, mag};
  assign ge_near = (m_ext >= T_NEAR);
  assign ge_over = (m_ext >= T_OVER);
  assign ge_high = (m_ext >= T_HIGH);

  always_comb begin
    if (ge_high)      code = RNG_HIGH;
    else if (ge_over) code = RNG_OVER;
    else if (ge_near) code = RNG_NEAR;
    else              code = RNG_QUIET;
  end

  always_comb begin
    a_r1_edges_nested: assert ((!ge_high || ge_over) && (!ge_over || ge_near));
  end

endmodule

// File: rtl/ovr_peak_hold.sv
module ovr_peak_hold
  import ovr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd,
  input  logic      clr,
  input  rng_code_t new_code,
  output rng_code_t peak
);

  rng_code_t base, nxt;

  assign base = clr ? RNG_QUIET : peak;
  assign nxt  = upd ? rng_max(base, new_code) : base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) peak <= RNG_QUIET;
    else        peak <= nxt;
  end

  a_r4_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> peak >= $past(peak));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(peak));

  a_r3_reaches_new: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> peak >= $past(new_code));

endmodule

// File: rtl/ovr_peak_top.sv
module ovr_peak_top
  import ovr_pkg::*;
#(
  parameter int W       = 16,
  parameter int TH_NEAR = 14600,
  parameter int TH_OVER = 16384,
  parameter int TH_HIGH = 18384
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_data,
  input  logic         stat_wr,
  input  logic         chan_en,
  output logic [1:0]   peak_code
);

  localparam int MW = W - 1;

  logic [MW-1:0] mag;
  logic          sat_hit;
  rng_code_t     smp_code;
  rng_code_t     peak;
  logic          ev_take;
  logic          ev_clear;

  assign ev_take  = smp_valid && chan_en;
  assign ev_clear = stat_wr || !chan_en;

  ovr_mag #(.W(W)) u_mag (
    .smp     (smp_data),
    .mag     (mag),
    .sat_hit (sat_hit)
  );

  ovr_classify #(
    .MW(MW), .TH_NEAR(TH_NEAR), .TH_OVER(TH_OVER), .TH_HIGH(TH_HIGH)
  ) u_cls (
    .mag  (mag),
    .code (smp_code)
  );

  ovr_peak_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (ev_take),
    .clr      (ev_clear),
    .new_code (smp_code),
    .peak     (peak)
  );

  assign peak_code = peak;

  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !smp_valid) |=> peak_code == 2'b00);

  a_r6_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> peak_code == 2'b00);

  a_r7_clear_and_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && ev_take) |=> peak_code == $past(smp_code));

  a_r2_min_is_top: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && sat_hit) |=> peak_code == 2'(RNG_HIGH));

endmodule

// File: tb/ovr_peak_top_tb_top.sv
module ovr_peak_top_tb_top;

  localparam int W       = 16;
  localparam int TH_NEAR = 14600;
  localparam int TH_OVER = 16384;
  localparam int TH_HIGH = 18384;
  localparam int MAXMAG  = (1 << (W-1)) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_valid = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic         stat_wr = 1'b0;
  logic         chan_en = 1'b1;
  logic [1:0]   peak_code;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 1'b0;

  typedef struct {
    int    exp;
    string tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  ovr_peak_top #(.W(W), .TH_NEAR(TH_NEAR), .TH_OVER(TH_OVER), .TH_HIGH(TH_HIGH)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .stat_wr(stat_wr), .chan_en(chan_en), .peak_code(peak_code)
  );

  function automatic int band(input int s);
    int m;
    m = (s < 0) ? -s : s;
    if (m > MAXMAG) m = MAXMAG;
    if (m >= TH_HIGH) return 3;
    if (m >= TH_OVER) return 2;
    if (m >= TH_NEAR) return 1;
    return 0;
  endfunction

  task automatic step(input bit v, input int d, input bit w, input bit e, input string tag);
    int base;
    int nxt;
    @(negedge clk);
    smp_valid = v;
    smp_data  = W'(d);
    stat_wr   = w;
    chan_en   = e;
    base = (w || !e) ? 0 : model;
    nxt  = base;
    if (v && e) nxt = (band(d) > base) ? band(d) : base;
    model = nxt;
    @(posedge clk);
    #1;
    sb.push_back('{exp: nxt, tag: tag});
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (int'(peak_code) != it.exp) begin
          fails++;
          $display("FAIL %s: peak_code=%0d expected=%0d", it.tag, peak_code, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (peak_code != 2'b00) begin
      fails++;
      $display("FAIL R8 reset: peak_code=%0d expected=0", peak_code);
    end
    rst_n = 1'b1;

    step(1, 100, 0, 1, "R1 small sample");
    step(1, TH_NEAR-1, 0, 1, "R1 just below near edge");
    step(1, TH_NEAR, 0, 1, "R1 R3 at near edge");
    step(1, -(TH_OVER-1), 0, 1, "R1 negative below over edge");
    step(1, -TH_OVER, 0, 1, "R1 R2 negative at over edge");
    step(1, 5, 0, 1, "R4 smaller sample keeps peak");
    step(0, 32767, 0, 1, "R4 invalid full scale ignored");
    step(1, TH_HIGH-1, 0, 1, "R1 just below high edge");
    step(0, 0, 1, 1, "R5 status write clears");
    step(1, -32768, 0, 1, "R2 most negative saturates to top band");
    step(0, 0, 1, 1, "R5 clear again");
    step(1, TH_HIGH, 0, 1, "R1 at high edge");
    step(1, 200, 1, 1, "R7 write with low sample");
    step(1, 17000, 0, 1, "R3 rise to over band");
    step(1, -20000, 1, 1, "R7 write with high sample");
    step(1, 14700, 0, 0, "R6 disabled clears, sample dropped");
    step(1, -32768, 0, 0, "R6 disabled ignores full scale");
    step(0, 0, 0, 0, "R6 stays clear");
    step(1, 15000, 0, 1, "R3 re-enabled sample counts");
    step(1, -14600, 0, 1, "R2 R4 negative near edge keeps peak");
    step(1, 32767, 0, 1, "R1 max positive");
    step(0, 0, 0, 1, "R4 idle hold");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule